// File: doc/BRIEF.md
# Serial flash command front end

This block is the slave-side protocol engine of a serial NOR flash. It watches the serial clock, the chip select and the serial data input. It captures the one-byte opcode that opens every transaction and looks it up in a decode table. The table gives each opcode its number of address bytes, whether a dummy byte follows, and whether data then flows out of the device or into it. Read-type commands stream bytes out, most significant bit first. Single-line reads use DQ1. The dual-line fast read drives two bits per clock on DQ1:DQ0.

Write-type commands only take effect when chip select rises with the clock count since it fell an exact multiple of eight. These commands are write enable, write disable, write status and write lock. Status writes and lock writes also need the write-enable latch to be set.

The engine runs on a fast system clock with a synchronous active-high reset. It samples the serial pins as signals that are already synchronous to that clock. Array bytes are fetched through a simple strobe-and-address memory port, with returned data expected on `rdata` one system clock after the strobe. Lock-register bytes are read and written through the same port. A write-status cycle keeps the block busy for a set number of system clocks. An external busy input covers program and erase cycles, which run outside the block. While busy, array and lock accesses are refused.

Top module: `sflash_cmd_engine`

## Requirements
- R1: Opcode bits are sampled on rising `sclk` edges, MSB first, starting with the first rising edge after `cs_n` falls. An opcode outside the table makes the block ignore the rest of the transaction: no output enable and no strobe until `cs_n` rises.
- R2: READ (03h) takes 3 address bytes, MSB first, then streams array bytes starting at that address. Each byte goes out MSB first on `dq_out[1]` with `dq_oe`=2'b10. The output changes after falling `sclk` edges. The address increments after each byte and wraps from FFFFFFh to 000000h.
- R3: FAST_READ (0Bh) behaves like READ, except that one dummy byte is clocked in between the address and the first data bit.
- R4: Dual read (3Bh) takes 3 address bytes and one dummy byte. It then outputs two bits per clock with `dq_oe`=2'b11: the higher bit of each pair on `dq_out[1]` and the lower on `dq_out[0]`, so one byte takes 4 clocks. The address increments and wraps as in R2.
- R5: Read status (05h) returns the status byte again and again while `cs_n` stays low. Bits 7..2 hold the protect bits, bit 1 the write-enable latch and bit 0 busy. After reset the status byte reads 00h.
- R6: Read identification (9Fh or 9Eh) returns the DEV_ID bytes, most significant byte first, then 00h.
- R7: Write enable (06h) sets the latch and write disable (04h) clears it. Either one acts only if `cs_n` rises when the clock count since `cs_n` fell is a nonzero multiple of 8.
- R8: Write status (01h) is followed by one data byte. It is executed only when all of these hold: the latch is set, the block is not busy, the byte-boundary rule of R7 is met, and at least one data byte has arrived. Executing it stores data bits 7..2 as the protect bits, clears the latch and holds busy for WR_CYCLES clocks. Otherwise nothing changes.
- R9: Write lock (E5h) takes 3 address bytes and one data byte. When executed under the same conditions as R8, it pulses `lk_wr` once after `cs_n` rises, with the address on `mem_addr` and the data on `lk_wdata`, and clears the latch. Without the latch set, no `lk_wr` pulse occurs.
- R10: Read lock (E8h) takes 3 address bytes, pulses `lk_rd` once with that address, and outputs the returned byte.
- R11: While busy (`ext_busy` high or a write-status cycle running), opcodes 03h, 0Bh, 3Bh and E8h are ignored: no strobe and no output enable. Read status still works and shows bit 0 set.
- R12: Raising `cs_n` part-way through a read output byte stops the output at once (`dq_oe`=0) and leaves no other effect. The next transaction works normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock (mode 0, idle low) |
| cs_n | input | 1 | Chip select, active low |
| dq0_in | input | 1 | Serial data input |
| dq_out | output | 2 | Serial data output, DQ1 in bit 1 |
| dq_oe | output | 2 | Output enables for DQ1:DQ0 |
| ext_busy | input | 1 | An external program or erase cycle is running |
| mem_addr | output | 8*ADDR_BYTES | Array or lock address |
| mem_rd | output | 1 | Array read strobe |
| lk_rd | output | 1 | Lock-register read strobe |
| lk_wr | output | 1 | Lock-register write strobe |
| lk_wdata | output | 8 | Lock-register write data |
| rdata | input | 8 | Byte returned one clock after a read strobe |

## Verification
The read path is driven from a table that mixes single-line, fast and dual-line reads at ordinary addresses and at addresses just below the top of the space. Comparing each byte with an address-derived pattern separates correct MSB ordering, correct dummy skipping, correct bit pairing and correct increment with wraparound. Write commands are tried both complete and with a few extra clocks before chip select rises, and both with and without the write-enable latch set. This exposes any missing byte-boundary or latch gating. The busy tests refuse reads during both an internal status-write cycle and an external busy, while the status read still returns the busy bit.

// File: rtl/sflash_pkg.sv
package sflash_pkg;

    typedef enum logic [3:0] {
        C_BAD, C_WREN, C_WRDI, C_RDID, C_RDSR, C_WRSR,
        C_WRLR, C_RDLR, C_READ, C_FAST, C_DOFR
    } cmd_t;

    typedef enum logic [2:0] {
        PH_OP, PH_ADDR, PH_DUMMY, PH_DATA, PH_IGN
    } phase_t;

    typedef struct packed {
        cmd_t kind;
        logic has_addr;
        logic has_dummy;
        logic is_read;
        logic is_write;
        logic needs_data;
        logic dual;
        logic gated;      // refused while busy
    } op_info_t;

    function automatic op_info_t decode_op(input logic [7:0] op);
        op_info_t r;
        r = '0;
        r.kind = C_BAD;
        case (op)
            8'h06: begin r.kind = C_WREN; r.is_write = 1'b1; end
            8'h04: begin r.kind = C_WRDI; r.is_write = 1'b1; end
            8'h9F, 8'h9E: begin r.kind = C_RDID; r.is_read = 1'b1; end
            8'h05: begin r.kind = C_RDSR; r.is_read = 1'b1; end
            8'h01: begin r.kind = C_WRSR; r.is_write = 1'b1; r.needs_data = 1'b1; end
            8'hE5: begin
                r.kind = C_WRLR; r.is_write = 1'b1; r.needs_data = 1'b1; r.has_addr = 1'b1;
            end
            8'hE8: begin
                r.kind = C_RDLR; r.is_read = 1'b1; r.has_addr = 1'b1; r.gated = 1'b1;
            end
            8'h03: begin
                r.kind = C_READ; r.is_read = 1'b1; r.has_addr = 1'b1; r.gated = 1'b1;
            end
            8'h0B: begin
                r.kind = C_FAST; r.is_read = 1'b1; r.has_addr = 1'b1; r.gated = 1'b1;
                r.has_dummy = 1'b1;
            end
            8'h3B: begin
                r.kind = C_DOFR; r.is_read = 1'b1; r.has_addr = 1'b1; r.gated = 1'b1;
                r.has_dummy = 1'b1; r.dual = 1'b1;
            end
            default: r.kind = C_BAD;
        endcase
        return r;
    endfunction

    function automatic logic is_array(input cmd_t k);
        return (k == C_READ) || (k == C_FAST) || (k == C_DOFR);
    endfunction

endpackage

// File: rtl/sflash_edges.sv
module sflash_edges (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    logic sclk_q;
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    assign sck_rise = sclk & ~sclk_q & ~cs_n;
    assign sck_fall = ~sclk & sclk_q & ~cs_n;
    assign cs_rise  = cs_n & ~cs_q;
endmodule

// File: rtl/sflash_status.sv
module sflash_status #(
    parameter int WR_CYCLES = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_wel,
    input  logic       clr_wel,
    input  logic       wr_stat,
    input  logic [5:0] wdata,
    input  logic       ext_busy,
    output logic       busy,
    output logic       wel,
    output logic [5:0] prot
);
    localparam int TW = $clog2(WR_CYCLES + 1);
    logic [TW-1:0] timer;

    always_ff @(posedge clk) begin
        if (rst) begin
            timer <= '0;
            wel   <= 1'b0;
            prot  <= '0;
        end else begin
            if (wr_stat) begin
                prot  <= wdata;
                timer <= TW'(WR_CYCLES);
                wel   <= 1'b0;
            end else begin
                if (timer != '0) timer <= timer - 1'b1;
                if (clr_wel) wel <= 1'b0;
                else if (set_wel) wel <= 1'b1;
            end
        end
    end

    assign busy = ext_busy | (timer != '0);

    // R8
    wrsr_busy_chk: assert property (@(posedge clk) disable iff (rst) wr_stat |=> busy);
    // R8
    wrsr_wel_clear_chk: assert property (@(posedge clk) disable iff (rst) wr_stat |=> !wel);
    // R7
    wel_set_chk: assert property (@(posedge clk) disable iff (rst)
        (set_wel && !wr_stat && !clr_wel) |=> wel);
endmodule

// File: rtl/sflash_outshift.sv
module sflash_outshift (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       shift,
    input  logic       dual,
    input  logic [7:0] din,
    output logic [1:0] dq
);
    logic [7:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
            dq <= '0;
        end else if (load) begin
            if (dual) begin
                dq <= din[7:6];
                sr <= {din[5:0], 2'b00};
            end else begin
                dq <= {din[7], 1'b0};
                sr <= {din[6:0], 1'b0};
            end
        end else if (shift) begin
            if (dual) begin
                dq <= sr[7:6];
                sr <= {sr[5:0], 2'b00};
            end else begin
                dq <= {sr[7], 1'b0};
                sr <= {sr[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
    import sflash_pkg::*;
#(
    parameter int                  ADDR_BYTES = 3,
    parameter int                  ID_BYTES   = 3,
    parameter logic [8*ID_BYTES-1:0] DEV_ID   = 24'h5AB317,
    parameter int                  WR_CYCLES  = 200
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sclk,
    input  logic                    cs_n,
    input  logic                    dq0_in,
    output logic [1:0]              dq_out,
    output logic [1:0]              dq_oe,
    input  logic                    ext_busy,
    output logic [8*ADDR_BYTES-1:0] mem_addr,
    output logic                    mem_rd,
    output logic                    lk_rd,
    output logic                    lk_wr,
    output logic [7:0]              lk_wdata,
    input  logic [7:0]              rdata
);
    localparam int AW  = 8 * ADDR_BYTES;
    localparam int ABW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam int IDW = $clog2(ID_BYTES + 1);

    logic sck_rise, sck_fall, cs_rise;
    logic busy, wel;
    logic [5:0] prot;

    phase_t   phase;
    op_info_t info, dec;
    logic [2:0]     bitcnt, clk_cnt, rcnt, ocnt, last_r;
    logic [6:0]     in_sr;
    logic [7:0]     in_byte, wbyte, src;
    logic [AW-2:0]  addr_sr;
    logic [AW-1:0]  addr_next;
    logic [ABW-1:0] abyte;
    logic [IDW-1:0] id_idx;
    logic           got, rd_phase, wr_ok;
    logic           do_wren, do_wrdi, do_wrsr, do_wrlr;
    logic [7:0]     id_arr [ID_BYTES+1];

    sflash_edges u_edges (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise)
    );

    // identification bytes, most significant first, then zero
    for (genvar i = 0; i < ID_BYTES; i++) begin : g_id
        assign id_arr[i] = DEV_ID[8*(ID_BYTES-1-i) +: 8];
    end
    assign id_arr[ID_BYTES] = 8'h00;

    assign in_byte   = {in_sr, dq0_in};
    assign addr_next = {addr_sr, dq0_in};
    assign dec       = decode_op(in_byte);
    assign rd_phase  = (phase == PH_DATA) && info.is_read;
    assign last_r    = info.dual ? 3'd3 : 3'd7;

    // write-type commit on chip select rising at a byte boundary
    assign wr_ok   = cs_rise && (phase == PH_DATA) && info.is_write && (clk_cnt == 3'd0)
                     && (!info.needs_data || got);
    assign do_wren = wr_ok && (info.kind == C_WREN);
    assign do_wrdi = wr_ok && (info.kind == C_WRDI);
    assign do_wrsr = wr_ok && (info.kind == C_WRSR) && wel && !busy;
    assign do_wrlr = wr_ok && (info.kind == C_WRLR) && wel && !busy;

    sflash_status #(.WR_CYCLES(WR_CYCLES)) u_status (
        .clk(clk), .rst(rst),
        .set_wel(do_wren), .clr_wel(do_wrdi | do_wrlr),
        .wr_stat(do_wrsr), .wdata(wbyte[7:2]), .ext_busy(ext_busy),
        .busy(busy), .wel(wel), .prot(prot)
    );

    always_comb begin
        case (info.kind)
            C_RDSR:  src = {prot, wel, busy};
            C_RDID:  src = id_arr[id_idx];
            default: src = rdata;
        endcase
    end

    sflash_outshift u_out (
        .clk(clk), .rst(rst),
        .load (sck_fall && rd_phase && (ocnt == 3'd0)),
        .shift(sck_fall && rd_phase && (ocnt != 3'd0)),
        .dual(info.dual), .din(src), .dq(dq_out)
    );

    assign dq_oe = (rd_phase && !cs_n) ? (info.dual ? 2'b11 : 2'b10) : 2'b00;

    always_ff @(posedge clk) begin
        mem_rd <= 1'b0;
        lk_rd  <= 1'b0;
        lk_wr  <= 1'b0;
        if (rst) begin
            phase    <= PH_OP;
            info     <= '0;
            bitcnt   <= '0;
            clk_cnt  <= '0;
            rcnt     <= '0;
            ocnt     <= '0;
            in_sr    <= '0;
            addr_sr  <= '0;
            abyte    <= '0;
            id_idx   <= '0;
            got      <= 1'b0;
            wbyte    <= '0;
            mem_addr <= '0;
            lk_wdata <= '0;
        end else begin
            if (do_wrlr) begin
                lk_wr    <= 1'b1;
                lk_wdata <= wbyte;
            end
            if (cs_n) begin
                phase   <= PH_OP;
                bitcnt  <= '0;
                clk_cnt <= '0;
                rcnt    <= '0;
                ocnt    <= '0;
                abyte   <= '0;
                id_idx  <= '0;
                got     <= 1'b0;
            end else begin
                if (sck_rise) begin
                    clk_cnt <= clk_cnt + 3'd1;
                    if (!rd_phase) begin
                        bitcnt <= bitcnt + 3'd1;
                        in_sr  <= in_byte[6:0];
                    end
                    case (phase)
                        PH_OP: if (bitcnt == 3'd7) begin
                            info <= dec;
                            if (dec.kind == C_BAD || (busy && dec.gated)) phase <= PH_IGN;
                            else if (dec.has_addr) phase <= PH_ADDR;
                            else phase <= PH_DATA;
                        end
                        PH_ADDR: begin
                            addr_sr <= addr_next[AW-2:0];
                            if (bitcnt == 3'd7) begin
                                if (abyte == ABW'(ADDR_BYTES - 1)) begin
                                    abyte    <= '0;
                                    mem_addr <= addr_next;
                                    if (is_array(info.kind)) mem_rd <= 1'b1;
                                    if (info.kind == C_RDLR) lk_rd <= 1'b1;
                                    phase <= info.has_dummy ? PH_DUMMY : PH_DATA;
                                end else begin
                                    abyte <= abyte + 1'b1;
                                end
                            end
                        end
                        PH_DUMMY: if (bitcnt == 3'd7) phase <= PH_DATA;
                        PH_DATA: begin
                            if (info.is_read) begin
                                if (rcnt == last_r) begin
                                    rcnt <= '0;
                                    if (is_array(info.kind)) begin
                                        mem_addr <= mem_addr + 1'b1;
                                        mem_rd   <= 1'b1;
                                    end
                                    if (info.kind == C_RDID && id_idx < IDW'(ID_BYTES))
                                        id_idx <= id_idx + 1'b1;
                                end else begin
                                    rcnt <= rcnt + 3'd1;
                                end
                            end else if (bitcnt == 3'd7 && !got) begin
                                got   <= 1'b1;
                                wbyte <= in_byte;
                            end
                        end
                        default: ;
                    endcase
                end
                if (sck_fall && rd_phase)
                    ocnt <= (ocnt == last_r) ? 3'd0 : ocnt + 3'd1;
            end
        end
    end

    // R2
    rd_strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst) mem_rd |=> !mem_rd);
    // R9
    lock_commit_chk: assert property (@(posedge clk) disable iff (rst)
        lk_wr |-> ($past(cs_n) && !$past(cs_n, 2)));
    // R10
    lock_rd_pulse_chk: assert property (@(posedge clk) disable iff (rst) lk_rd |=> !lk_rd);
endmodule

// File: tb/tb_sflash_cmd_engine.sv
module tb_sflash_cmd_engine;
    localparam int HALF = 4;

    logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, cs_n = 1'b1, dq0 = 1'b0, ext_busy = 1'b0;
    logic [1:0]  dq_out, dq_oe;
    logic [23:0] mem_addr;
    logic        mem_rd, lk_rd, lk_wr;
    logic [7:0]  lk_wdata, rdata = 8'h00, lock_q = 8'h00;
    logic [23:0] lk_addr_q = 24'h0;
    int errors = 0, checks = 0;
    int rd_cnt = 0, lkrd_cnt = 0, lkwr_cnt = 0, oe_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sflash_cmd_engine #(.WR_CYCLES(2000)) dut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .dq0_in(dq0),
        .dq_out(dq_out), .dq_oe(dq_oe), .ext_busy(ext_busy),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .lk_rd(lk_rd), .lk_wr(lk_wr),
        .lk_wdata(lk_wdata), .rdata(rdata)
    );

    function automatic logic [7:0] memf(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    always @(posedge clk) begin
        if (mem_rd) begin rdata <= memf(mem_addr); rd_cnt <= rd_cnt + 1; end
        else if (lk_rd) begin rdata <= lock_q; lkrd_cnt <= lkrd_cnt + 1; end
        if (lk_wr) begin lock_q <= lk_wdata; lk_addr_q <= mem_addr; lkwr_cnt <= lkwr_cnt + 1; end
        if (dq_oe != 2'b00) oe_cnt <= oe_cnt + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sck(input logic din, output logic [1:0] q);
        sclk = 1'b0; dq0 = din;
        repeat (HALF) @(negedge clk);
        q = dq_out;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_start();
        @(negedge clk); cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_end();
        @(negedge clk); sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic [1:0] q;
        for (int i = 7; i >= 0; i--) sck(b[i], q);
    endtask

    task automatic send_addr(input logic [23:0] a);
        send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
    endtask

    task automatic recv_byte(input bit dual, output logic [7:0] b);
        logic [1:0] q;
        b = 8'h00;
        if (dual) for (int i = 0; i < 4; i++) begin sck(1'b0, q); b = {b[5:0], q}; end
        else      for (int i = 0; i < 8; i++) begin sck(1'b0, q); b = {b[6:0], q[1]}; end
    endtask

    task automatic do_read(input logic [7:0] op, input logic [23:0] addr, input int n);
        logic [7:0] b;
        string tag;
        tag = (op == 8'h03) ? "R2" : (op == 8'h0B) ? "R3" : "R4";
        cs_start(); send_byte(op); send_addr(addr);
        if (op != 8'h03) send_byte(8'h00);
        for (int i = 0; i < n; i++) begin
            recv_byte(op == 8'h3B, b);
            check(tag, {24'h0, b}, {24'h0, memf(addr + 24'(i))});
        end
        check(tag, {30'h0, dq_oe}, (op == 8'h3B) ? 32'h3 : 32'h2);
        cs_end();
    endtask

    task automatic cmd_only(input logic [7:0] op, input int extra);
        logic [1:0] q;
        cs_start(); send_byte(op);
        for (int i = 0; i < extra; i++) sck(1'b1, q);
        cs_end();
    endtask

    task automatic cmd_data(input logic [7:0] op, input logic [23:0] a, input bit with_addr,
                            input logic [7:0] d, input int extra);
        logic [1:0] q;
        cs_start(); send_byte(op);
        if (with_addr) send_addr(a);
        send_byte(d);
        for (int i = 0; i < extra; i++) sck(1'b0, q);
        cs_end();
    endtask

    task automatic status_chk(input string req, input logic [7:0] exp, input int n);
        logic [7:0] b;
        cs_start(); send_byte(8'h05);
        for (int i = 0; i < n; i++) begin recv_byte(1'b0, b); check(req, {24'h0, b}, {24'h0, exp}); end
        cs_end();
    endtask

    typedef struct packed { logic [7:0] op; logic [23:0] addr; logic [3:0] n; } vec_t;
    localparam vec_t VEC [6] = '{
        '{8'h03, 24'h000010, 4'd4},
        '{8'h0B, 24'h001234, 4'd3},
        '{8'h3B, 24'h00ABCD, 4'd3},
        '{8'h03, 24'hFFFFFE, 4'd4},
        '{8'h3B, 24'hFFFFFF, 4'd2},
        '{8'h0B, 24'h80C001, 4'd2}
    };

    initial begin
        int r0, o0, l0;
        logic [7:0] b;
        logic [1:0] q;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // reset state
        check("R12", {30'h0, dq_oe}, 32'h0);
        check("R2", rd_cnt, 0);
        status_chk("R5", 8'h00, 1);

        for (int v = 0; v < 6; v++) do_read(VEC[v].op, VEC[v].addr, int'(VEC[v].n));

        // R6 identification
        cs_start(); send_byte(8'h9F);
        recv_byte(1'b0, b); check("R6", {24'h0, b}, 32'h5A);
        recv_byte(1'b0, b); check("R6", {24'h0, b}, 32'hB3);
        recv_byte(1'b0, b); check("R6", {24'h0, b}, 32'h17);
        recv_byte(1'b0, b); check("R6", {24'h0, b}, 32'h00);
        cs_end();
        cs_start(); send_byte(8'h9E); recv_byte(1'b0, b); check("R6", {24'h0, b}, 32'h5A); cs_end();

        // R7 latch set/clear and byte-boundary rule
        cmd_only(8'h06, 0); status_chk("R7", 8'h02, 1);
        cmd_only(8'h04, 0); status_chk("R7", 8'h00, 1);
        cmd_only(8'h06, 3); status_chk("R7", 8'h00, 1);

        // R8 write status without latch, then with latch
        cmd_data(8'h01, 24'h0, 1'b0, 8'hFC, 0); status_chk("R8", 8'h00, 1);
        cmd_only(8'h06, 0);
        cmd_data(8'h01, 24'h0, 1'b0, 8'hFC, 0);
        status_chk("R8", 8'hFD, 2);

        // R11 read refused during internal cycle
        r0 = rd_cnt; o0 = oe_cnt;
        cs_start(); send_byte(8'h03); send_addr(24'h000020);
        for (int i = 0; i < 8; i++) sck(1'b0, q);
        cs_end();
        check("R11", rd_cnt, r0); check("R11", oe_cnt, o0);
        repeat (2100) @(negedge clk);
        status_chk("R8", 8'hFC, 1);

        // R8 partial write status rejected
        cmd_only(8'h06, 0);
        cmd_data(8'h01, 24'h0, 1'b0, 8'h00, 3);
        status_chk("R8", 8'hFE, 1);

        // R9 / R10 lock write then read
        l0 = lkwr_cnt;
        cmd_data(8'hE5, 24'h012300, 1'b1, 8'hA5, 0);
        check("R9", lkwr_cnt, l0 + 1);
        check("R9", {8'h0, lk_addr_q}, 32'h012300);
        status_chk("R9", 8'hFC, 1);
        r0 = lkrd_cnt;
        cs_start(); send_byte(8'hE8); send_addr(24'h012300);
        recv_byte(1'b0, b); check("R10", {24'h0, b}, 32'hA5);
        cs_end();
        check("R10", lkrd_cnt, r0 + 1);
        l0 = lkwr_cnt;
        cmd_data(8'hE5, 24'h012300, 1'b1, 8'h11, 0);
        check("R9", lkwr_cnt, l0);

        // R1 unknown opcode ignored
        r0 = rd_cnt; o0 = oe_cnt; l0 = lkrd_cnt;
        cs_start(); send_byte(8'hFF); send_addr(24'h000000);
        for (int i = 0; i < 16; i++) sck(1'b0, q);
        cs_end();
        check("R1", rd_cnt, r0); check("R1", oe_cnt, o0); check("R1", lkrd_cnt, l0);

        // R12 chip select rise mid-byte
        cs_start(); send_byte(8'h03); send_addr(24'h000040);
        for (int i = 0; i < 3; i++) sck(1'b0, q);
        check("R12", {30'h0, dq_oe}, 32'h2);
        cs_end();
        check("R12", {30'h0, dq_oe}, 32'h0);
        do_read(8'h03, 24'h000041, 1);

        // R11 external busy
        ext_busy = 1'b1;
        r0 = rd_cnt; o0 = oe_cnt; l0 = lkrd_cnt;
        cs_start(); send_byte(8'h3B); send_addr(24'h000050); send_byte(8'h00);
        for (int i = 0; i < 8; i++) sck(1'b0, q);
        cs_end();
        cs_start(); send_byte(8'hE8); send_addr(24'h012300);
        for (int i = 0; i < 8; i++) sck(1'b0, q);
        cs_end();
        check("R11", rd_cnt, r0); check("R11", oe_cnt, o0); check("R11", lkrd_cnt, l0);
        status_chk("R11", 8'hFD, 1);
        ext_busy = 1'b0;
        repeat (4) @(negedge clk);
        do_read(8'h03, 24'h000050, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule